// File: doc/BRIEF.md
# Outstanding-Miss Response Tracker

This block holds the bookkeeping for one outstanding cache miss while it waits for its coherence responses. Each incoming response is either a DATA message carrying an expected-acknowledgement count or a single ACK from another processor. The block sorts each response into one of five events that the line controller acts on. It also keeps a running, signed count of the acknowledgements that are still owed.

Acknowledgements can overtake the data message that announces how many to expect. The count therefore goes negative when that happens. The final response is found by adding the carried count to the tracked count.

Alongside the count, the entry keeps a prefetch flag and a bitmask of processors whose forwarded read requests must be served once the line arrives. It also keeps one forwarded exclusive-request holder, stored as that processor's ID and the ack count its request carried. Message transport and data storage are handled elsewhere.

Top module: `miss_entry_tracker`

## Requirements
- R1: After reset, `busy_o`, `prefetch_o`, `getx_valid_o`, `proto_err_o` and `evt_valid_o` are 0, and `pending_o` and `gets_mask_o` are all zero.
- R2: `alloc_i` in a cycle makes `busy_o` 1 from the next cycle, with `pending_o`, `prefetch_o`, `gets_mask_o` and `getx_valid_o` cleared, whatever they held before.
- R3: A DATA response (`rsp_is_ack_i`=0) with carried count 0 yields `evt_code_o`=1 in the same cycle and leaves `pending_o` unchanged.
- R4: A DATA response with a nonzero carried count whose sum with `pending_o` is nonzero yields code 2, and `pending_o` becomes that sum.
- R5: A DATA response with a nonzero carried count whose sum with `pending_o` is zero yields code 3, and `pending_o` becomes 0.
- R6: An ACK response (`rsp_is_ack_i`=1) while `pending_o` is not 1 yields code 4 and decrements `pending_o` by one, which may take it below zero.
- R7: An ACK response while `pending_o` is 1 yields code 5, and `pending_o` becomes 0.
- R8: `set_pf_i` while an entry is held sets `prefetch_o` from the next cycle.
- R9: `fwd_gets_i` sets bit `fwd_req_id_i` of `gets_mask_o`; recorded bits accumulate and stay set until deallocation.
- R10: `fwd_getx_i` stores `fwd_req_id_i` and `fwd_acks_i` in `getx_id_o` and `getx_acks_o` and sets `getx_valid_o`; a later record replaces the earlier one.
- R11: `dealloc_i` drops `busy_o` and clears the count, the prefetch flag, the mask and `getx_valid_o` from the next cycle.
- R12: A response or record strobe while no entry is held produces no event, changes no field, and sets `proto_err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Start a fresh entry |
| dealloc_i | input | 1 | Release the entry |
| set_pf_i | input | 1 | Mark the miss as a prefetch |
| rsp_valid_i | input | 1 | Response present this cycle |
| rsp_is_ack_i | input | 1 | 1 = ACK, 0 = DATA |
| rsp_acks_i | input | CW | Signed ack count carried by a DATA response |
| fwd_gets_i | input | 1 | Record a forwarded read requester |
| fwd_getx_i | input | 1 | Record a forwarded exclusive requester |
| fwd_req_id_i | input | IDW | Requester ID for the record strobes |
| fwd_acks_i | input | CW | Ack count carried by a forwarded exclusive request |
| evt_valid_o | output | 1 | Classified event present this cycle |
| evt_code_o | output | 3 | 1 data-zero, 2 data-more, 3 data-last, 4 ack, 5 last-ack, 0 none |
| busy_o | output | 1 | Entry held |
| pending_o | output | CW | Signed pending-ack count |
| prefetch_o | output | 1 | Prefetch flag |
| gets_mask_o | output | N_REQ | Forwarded read requesters |
| getx_valid_o | output | 1 | Exclusive requester recorded |
| getx_id_o | output | IDW | Exclusive requester ID |
| getx_acks_o | output | CW | Exclusive requester ack count |
| proto_err_o | output | 1 | Sticky strobe-while-idle flag |

## Verification
Two ACKs are sent ahead of the data. This drives the count to -2, so a following DATA with count 3 lands on data-more, while a fresh entry that gets a DATA with count 2 after two early ACKs lands on data-last. Those two cases separate the sum-based test from a test on the carried count alone.

An ACK that arrives with the count at exactly 1 is set against ACKs at 0 and -1, which checks the last-ack boundary. A zero-count DATA checks that that path leaves the count alone.

Two exclusive records in a row and two read records with different IDs separate overwrite from accumulation. Strobes while idle, followed by a re-allocation, show that the error flag is sticky and that allocation clears stale fields.

// File: rtl/miss_entry_tracker.sv
module miss_entry_tracker #(
  parameter int N_REQ = 4,
  parameter int CW    = 8,
  localparam int IDW  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_i,
  input  logic                 dealloc_i,
  input  logic                 set_pf_i,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_is_ack_i,
  input  logic signed [CW-1:0] rsp_acks_i,
  input  logic                 fwd_gets_i,
  input  logic                 fwd_getx_i,
  input  logic [IDW-1:0]       fwd_req_id_i,
  input  logic [CW-1:0]        fwd_acks_i,
  output logic                 evt_valid_o,
  output logic [2:0]           evt_code_o,
  output logic                 busy_o,
  output logic signed [CW-1:0] pending_o,
  output logic                 prefetch_o,
  output logic [N_REQ-1:0]     gets_mask_o,
  output logic                 getx_valid_o,
  output logic [IDW-1:0]       getx_id_o,
  output logic [CW-1:0]        getx_acks_o,
  output logic                 proto_err_o
);
  localparam logic [2:0] EV_NONE = 3'd0, EV_DZERO = 3'd1, EV_DMORE = 3'd2,
                         EV_DLAST = 3'd3, EV_ACK = 3'd4, EV_ALAST = 3'd5;

  logic signed [CW-1:0] sum;
  logic signed [CW-1:0] pend_nxt;
  logic [N_REQ-1:0]     gets_bit;
  logic                 stray;
  logic                 take;

  assign sum      = pending_o + rsp_acks_i;
  assign gets_bit = N_REQ'(1) << fwd_req_id_i;
  assign stray    = (rsp_valid_i | fwd_gets_i | fwd_getx_i) & ~busy_o;
  assign take     = busy_o & ~alloc_i & ~dealloc_i;
  assign evt_valid_o = rsp_valid_i & take;

  always_comb begin
    evt_code_o = EV_NONE;
    pend_nxt   = pending_o;
    if (evt_valid_o) begin
      if (rsp_is_ack_i) begin
        evt_code_o = (pending_o == CW'(1)) ? EV_ALAST : EV_ACK;
        pend_nxt   = pending_o - CW'(1);
      end else if (rsp_acks_i == '0) begin
        evt_code_o = EV_DZERO;
      end else begin
        evt_code_o = (sum == '0) ? EV_DLAST : EV_DMORE;
        pend_nxt   = sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o       <= 1'b0;
      pending_o    <= '0;
      prefetch_o   <= 1'b0;
      gets_mask_o  <= '0;
      getx_valid_o <= 1'b0;
      getx_id_o    <= '0;
      getx_acks_o  <= '0;
      proto_err_o  <= 1'b0;
    end else begin
      if (stray) proto_err_o <= 1'b1;
      if (alloc_i || dealloc_i) begin
        busy_o       <= alloc_i;
        pending_o    <= '0;
        prefetch_o   <= 1'b0;
        gets_mask_o  <= '0;
        getx_valid_o <= 1'b0;
        getx_id_o    <= '0;
        getx_acks_o  <= '0;
      end else if (busy_o) begin
        pending_o <= pend_nxt;
        if (set_pf_i)   prefetch_o  <= 1'b1;
        if (fwd_gets_i) gets_mask_o <= gets_mask_o | gets_bit;
        if (fwd_getx_i) begin
          getx_valid_o <= 1'b1;
          getx_id_o    <= fwd_req_id_i;
          getx_acks_o  <= fwd_acks_i;
        end
      end
    end
  end
endmodule

// File: rtl/miss_entry_tracker_chk.sv
module miss_entry_tracker_chk #(
  parameter int N_REQ = 4,
  parameter int CW    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_i,
  input logic                 dealloc_i,
  input logic                 evt_valid_o,
  input logic [2:0]           evt_code_o,
  input logic signed [CW-1:0] pending_o,
  input logic                 prefetch_o,
  input logic [N_REQ-1:0]     gets_mask_o,
  input logic                 busy_o,
  input logic                 proto_err_o
);
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  assert_alloc_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (busy_o && pending_o == '0 && !prefetch_o && gets_mask_o == '0));

  assert_ack_decrements_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == 3'd4) |=> pending_o == $past(pending_o) - CW'(1));

  assert_last_ack_from_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == 3'd5) |=> pending_o == '0);

  assert_data_last_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == 3'd3) |=> pending_o == '0);

  assert_mask_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !alloc_i && !dealloc_i) |=> (gets_mask_o & $past(gets_mask_o)) == $past(gets_mask_o));

  assert_idle_no_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !evt_valid_o);
endmodule

bind miss_entry_tracker miss_entry_tracker_chk #(.N_REQ(N_REQ), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .dealloc_i(dealloc_i),
  .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o), .pending_o(pending_o),
  .prefetch_o(prefetch_o), .gets_mask_o(gets_mask_o), .busy_o(busy_o),
  .proto_err_o(proto_err_o)
);

// File: tb/miss_entry_tracker_tb.sv
`timescale 1ns/1ps
module miss_entry_tracker_tb;
  localparam int N_REQ = 4;
  localparam int CW = 8;
  localparam int IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_i = 0, dealloc_i = 0, set_pf_i = 0, rsp_valid_i = 0, rsp_is_ack_i = 0;
  logic signed [CW-1:0] rsp_acks_i = '0;
  logic fwd_gets_i = 0, fwd_getx_i = 0;
  logic [IDW-1:0] fwd_req_id_i = '0;
  logic [CW-1:0] fwd_acks_i = '0;
  logic evt_valid_o, busy_o, prefetch_o, getx_valid_o, proto_err_o;
  logic [2:0] evt_code_o;
  logic signed [CW-1:0] pending_o;
  logic [N_REQ-1:0] gets_mask_o;
  logic [IDW-1:0] getx_id_o;
  logic [CW-1:0] getx_acks_o;

  int tests = 0, fails = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  miss_entry_tracker #(.N_REQ(N_REQ), .CW(CW)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    int e;
    if (rst_n && evt_valid_o) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R12: actual event %0d expected none", evt_code_o);
      end else begin
        e = exp_q.pop_front();
        if (int'(evt_code_o) != e) begin
          fails++;
          $display("FAIL R3-R7 event: actual %0d expected %0d", evt_code_o, e);
        end
      end
    end
  end

  task automatic pulse_ctl(bit a, bit d, bit p);
    @(posedge clk); #1;
    alloc_i = a; dealloc_i = d; set_pf_i = p;
    @(posedge clk); #1;
    alloc_i = 0; dealloc_i = 0; set_pf_i = 0;
  endtask

  task automatic rsp(bit is_ack, int acks, int exp_code);
    if (exp_code != 0) exp_q.push_back(exp_code);
    @(posedge clk); #1;
    rsp_valid_i = 1; rsp_is_ack_i = is_ack; rsp_acks_i = CW'(acks);
    @(posedge clk); #1;
    rsp_valid_i = 0; rsp_is_ack_i = 0; rsp_acks_i = '0;
  endtask

  task automatic rec(bit gets, bit getx, int id, int acks);
    @(posedge clk); #1;
    fwd_gets_i = gets; fwd_getx_i = getx; fwd_req_id_i = IDW'(id); fwd_acks_i = CW'(acks);
    @(posedge clk); #1;
    fwd_gets_i = 0; fwd_getx_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy_o, 0);
    chk("R1 pending", int'(pending_o), 0);
    chk("R1 mask", gets_mask_o, 0);
    chk("R1 err", proto_err_o, 0);
    chk("R1 getx", getx_valid_o, 0);
    rst_n = 1;

    pulse_ctl(1, 0, 0);
    chk("R2 busy", busy_o, 1);
    chk("R2 pending", int'(pending_o), 0);
    pulse_ctl(0, 0, 1);
    chk("R8 prefetch", prefetch_o, 1);

    rsp(1, 0, 4);
    chk("R6 pending -1", int'(pending_o), -1);
    rsp(1, 0, 4);
    chk("R6 pending -2", int'(pending_o), -2);
    rsp(0, 3, 2);
    chk("R4 pending sum", int'(pending_o), 1);
    rsp(1, 0, 5);
    chk("R7 pending zero", int'(pending_o), 0);
    rsp(0, 0, 1);
    chk("R3 pending kept", int'(pending_o), 0);
    rsp(0, 2, 2);
    chk("R4 pending 2", int'(pending_o), 2);
    rsp(1, 0, 4);
    chk("R6 pending 1", int'(pending_o), 1);

    rec(1, 0, 1, 0);
    rec(1, 0, 3, 0);
    chk("R9 mask accumulates", gets_mask_o, 'b1010);
    rec(0, 1, 2, 5);
    chk("R10 getx valid", getx_valid_o, 1);
    chk("R10 getx id", getx_id_o, 2);
    chk("R10 getx acks", getx_acks_o, 5);
    rec(0, 1, 0, 7);
    chk("R10 getx id overwrite", getx_id_o, 0);
    chk("R10 getx acks overwrite", getx_acks_o, 7);
    chk("R9 mask held", gets_mask_o, 'b1010);

    pulse_ctl(1, 0, 0);
    chk("R2 realloc pending", int'(pending_o), 0);
    chk("R2 realloc prefetch", prefetch_o, 0);
    chk("R2 realloc mask", gets_mask_o, 0);
    chk("R2 realloc getx", getx_valid_o, 0);
    rsp(1, 0, 4);
    rsp(1, 0, 4);
    rsp(0, 2, 3);
    chk("R5 pending zero", int'(pending_o), 0);

    pulse_ctl(0, 0, 1);
    rec(1, 0, 2, 0);
    pulse_ctl(0, 1, 0);
    chk("R11 busy", busy_o, 0);
    chk("R11 mask", gets_mask_o, 0);
    chk("R11 prefetch", prefetch_o, 0);

    @(posedge clk); #1;
    rsp_valid_i = 1; rsp_is_ack_i = 1;
    @(negedge clk);
    chk("R12 no event idle", evt_valid_o, 0);
    @(posedge clk); #1;
    rsp_valid_i = 0; rsp_is_ack_i = 0;
    chk("R12 err set", proto_err_o, 1);
    chk("R12 pending untouched", int'(pending_o), 0);
    rec(1, 0, 1, 0);
    chk("R12 mask untouched", gets_mask_o, 0);
    pulse_ctl(1, 0, 0);
    chk("R12 err sticky", proto_err_o, 1);

    repeat (2) @(posedge clk);
    chk("R3-R7 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule